// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between two parallel buses, A and B, in both directions. Each direction has its own storage register. A rising edge on that direction's capture strobe loads the register from the source bus. Loading does not depend on the source-select, direction or output-enable controls.

A per-direction source select picks what the driven bus receives: live data from the opposite bus, or the stored register contents. The driven data is the bitwise complement of the selected value. Each bus pin group is modelled as separate input, output and output-enable vectors, so no internal tristate is needed.

When both directions select live data and both sides are enabled to drive, the block enters a bus-hold mode. The A side drives back the registered A bus value, and the B side drives its complement. Once all other drivers release the buses, both keep their last state.

Top module: `dual_bus_xcvr`

## Requirements
- R1: After a synchronous active-high reset, both storage registers hold all zeros. With stored source selected, a_out and b_out are therefore all ones.
- R2: A system-clock edge at which cap_ab is sampled high, having been low at the previous edge, loads the A-to-B register from a_in. The same rule loads the B-to-A register from b_in using cap_ba. At any other edge both registers keep their value.
- R3: Register loading happens for every value of sel_ab_stored, sel_ba_stored, b_drive_en and a_drive_n.
- R4: Source select value 0 picks live data from the opposite bus, and value 1 picks that direction's register. b_out uses sel_ab_stored with a_in or the A-to-B register; a_out uses sel_ba_stored with b_in or the B-to-A register.
- R5: Outside bus-hold mode, each bus output is the bitwise complement of its selected data.
- R6: Bus-hold mode is active when sel_ab_stored=0, sel_ba_stored=0, b_drive_en=1 and a_drive_n=0. In this mode a_out equals a_in as sampled at the previous clock edge, and b_out is its complement. The values persist after external drivers release the A bus.
- R7: b_oe is all ones exactly when b_drive_en=1, otherwise all zeros. a_oe is all ones exactly when a_drive_n=0, otherwise all zeros.
- R8: In stored mode, the output keeps the complement of the captured value after the live source bus changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_ab | input | 1 | A-to-B capture strobe, loads on rising edge |
| cap_ba | input | 1 | B-to-A capture strobe, loads on rising edge |
| sel_ab_stored | input | 1 | B-side source: 0 live A, 1 stored |
| sel_ba_stored | input | 1 | A-side source: 0 live B, 1 stored |
| b_drive_en | input | 1 | Active-high enable for driving bus B |
| a_drive_n | input | 1 | Active-low enable for driving bus A |
| a_in | input | WIDTH | Resolved value on bus A |
| a_out | output | WIDTH | Data driven onto bus A |
| a_oe | output | WIDTH | Per-bit drive enable for bus A |
| b_in | input | WIDTH | Resolved value on bus B |
| b_out | output | WIDTH | Data driven onto bus B |
| b_oe | output | WIDTH | Per-bit drive enable for bus B |

## Verification
The bench builds the block with WIDTH=8 and INVERT_OUT=1, which is the inverting eight-bit variant. Randomly drawn data, selects and strobes cover all sixteen control combinations, including bus-hold. Strobes are also toggled while the enables are varied. A bench bus model lets A read back its own driver, which makes the persistence of bus-hold observable after the external source releases.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_sel_e;

   function automatic logic hold_mode_active(input logic sel_ab, input logic sel_ba,
                                             input logic b_en, input logic a_en_n);
      return (sel_ab == SRC_LIVE) && (sel_ba == SRC_LIVE) && b_en && !a_en_n;
   endfunction
endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             strobe,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic strobe_q;
   logic load;

   initial begin
      if (WIDTH < 1) $error("xcvr_capture: WIDTH must be at least 1");
   end

   assign load = strobe && !strobe_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         strobe_q <= 1'b0;
         q        <= '0;
      end else begin
         strobe_q <= strobe;
         if (load) q <= d;
      end
   end

   AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
      (strobe && !strobe_q) |=> (q == $past(d))); // R2

   AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !(strobe && !strobe_q) |=> $stable(q)); // R2
endmodule

// File: rtl/xcvr_hold.sv
module xcvr_hold #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= bus_in;
   end
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
   parameter int WIDTH      = 8,
   parameter bit INVERT_OUT = 1'b1,
   parameter bit HOLD_COMPL = 1'b0
) (
   input  logic             sel_stored,
   input  logic             hold_mode,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   input  logic [WIDTH-1:0] hold_val,
   output logic [WIDTH-1:0] out
);
   logic [WIDTH-1:0] picked;
   logic [WIDTH-1:0] polar;
   logic [WIDTH-1:0] hold_drv;

   assign picked = sel_stored ? stored : live;

   generate
      if (INVERT_OUT) begin : g_inv
         assign polar = ~picked;
         if (HOLD_COMPL) begin : g_hc
            assign hold_drv = ~hold_val;
         end else begin : g_ht
            assign hold_drv = hold_val;
         end
      end else begin : g_true
         assign polar    = picked;
         assign hold_drv = hold_val;
      end
   endgenerate

   assign out = hold_mode ? hold_drv : polar;
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
   import xcvr_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit INVERT_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_ab,
   input  logic             cap_ba,
   input  logic             sel_ab_stored,
   input  logic             sel_ba_stored,
   input  logic             b_drive_en,
   input  logic             a_drive_n,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe
);
   localparam logic [WIDTH-1:0] ALL_ON = {WIDTH{1'b1}};

   logic [WIDTH-1:0] reg_ab;
   logic [WIDTH-1:0] reg_ba;
   logic [WIDTH-1:0] a_hold;
   logic             hold;

   initial begin
      if (WIDTH < 1 || WIDTH > 1024) $error("dual_bus_xcvr: WIDTH out of range");
   end

   assign hold = hold_mode_active(sel_ab_stored, sel_ba_stored, b_drive_en, a_drive_n);

   xcvr_capture #(.WIDTH(WIDTH)) u_cap_ab (
      .clk(clk), .rst(rst), .strobe(cap_ab), .d(a_in), .q(reg_ab));

   xcvr_capture #(.WIDTH(WIDTH)) u_cap_ba (
      .clk(clk), .rst(rst), .strobe(cap_ba), .d(b_in), .q(reg_ba));

   xcvr_hold #(.WIDTH(WIDTH)) u_hold (
      .clk(clk), .rst(rst), .bus_in(a_in), .q(a_hold));

   xcvr_drive #(.WIDTH(WIDTH), .INVERT_OUT(INVERT_OUT), .HOLD_COMPL(1'b1)) u_drv_b (
      .sel_stored(sel_ab_stored), .hold_mode(hold), .live(a_in), .stored(reg_ab),
      .hold_val(a_hold), .out(b_out));

   xcvr_drive #(.WIDTH(WIDTH), .INVERT_OUT(INVERT_OUT), .HOLD_COMPL(1'b0)) u_drv_a (
      .sel_stored(sel_ba_stored), .hold_mode(hold), .live(b_in), .stored(reg_ba),
      .hold_val(a_hold), .out(a_out));

   assign b_oe = b_drive_en ? ALL_ON : '0;
   assign a_oe = a_drive_n  ? '0 : ALL_ON;

   AST_HOLD_PERSIST: assert property (@(posedge clk) disable iff (rst)
      (hold && !$past(rst)) |-> (a_out == $past(a_in))); // R6

   AST_HOLD_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
      (hold && INVERT_OUT) |-> (b_out == ~a_out)); // R6

   AST_STORED_B_INVERTED: assert property (@(posedge clk) disable iff (rst)
      (sel_ab_stored && INVERT_OUT) |-> (b_out == ~reg_ab)); // R5

   AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (rst)
      ($countones(a_oe) == 0 || $countones(a_oe) == WIDTH) &&
      ($countones(b_oe) == 0 || $countones(b_oe) == WIDTH)); // R7
endmodule

// File: tb/dual_bus_xcvr_test.sv
module dual_bus_xcvr_test;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst;
   logic cap_ab, cap_ba, sab, sba, ben, adn;
   logic ext_a_en;
   logic [W-1:0] ext_a, ext_b;
   logic [W-1:0] a_in, a_out, a_oe, b_in, b_out, b_oe;

   int checks = 0;
   int failures = 0;

   logic [W-1:0] m_ab, m_ba, m_hold;
   logic m_pab, m_pba;

   always #10 clk = ~clk;

   assign a_in = ext_a_en ? ext_a : (a_out & a_oe);
   assign b_in = ext_b;

   dual_bus_xcvr #(.WIDTH(W), .INVERT_OUT(1'b1)) uut (
      .clk(clk), .rst(rst), .cap_ab(cap_ab), .cap_ba(cap_ba),
      .sel_ab_stored(sab), .sel_ba_stored(sba), .b_drive_en(ben), .a_drive_n(adn),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] exp_b();
      if (!sab && !sba && ben && !adn) return ~m_hold;
      return sab ? ~m_ab : ~a_in;
   endfunction

   function automatic logic [W-1:0] exp_a();
      if (!sab && !sba && ben && !adn) return m_hold;
      return sba ? ~m_ba : ~b_in;
   endfunction

   // inputs set beforehand; one clock edge, update model, settle
   task automatic step();
      logic [W-1:0] av;
      @(posedge clk);
      av = a_in;
      if (rst) begin
         m_ab = '0; m_ba = '0; m_hold = '0; m_pab = 0; m_pba = 0;
      end else begin
         if (cap_ab && !m_pab) m_ab = av;
         if (cap_ba && !m_pba) m_ba = b_in;
         m_pab = cap_ab; m_pba = cap_ba;
         m_hold = av;
      end
      #5;
   endtask

   task automatic check_all(input string tag);
      chk({tag, " R4/R5 b_out"}, b_out, exp_b());
      chk({tag, " R4/R5 a_out"}, a_out, exp_a());
      chk({tag, " R7 b_oe"}, b_oe, ben ? '1 : '0);
      chk({tag, " R7 a_oe"}, a_oe, adn ? '0 : '1);
   endtask

   initial begin
      #3000000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd1651;
      void'($urandom(seed));
      rst = 1; cap_ab = 0; cap_ba = 0; sab = 1; sba = 1; ben = 1; adn = 0;
      ext_a_en = 1; ext_a = 8'h3C; ext_b = 8'hC3;
      step(); step();
      rst = 0;
      step();
      // R1: registers zero -> stored outputs all ones
      chk("R1 reset b_out", b_out, 8'hFF);
      chk("R1 reset a_out", a_out, 8'hFF);

      // R3: capture with drivers disabled and live selects
      sab = 0; sba = 0; ben = 0; adn = 1; ext_a = 8'h96; ext_b = 8'h1E;
      cap_ab = 1; cap_ba = 1; step();
      cap_ab = 0; cap_ba = 0; step();
      sab = 1; sba = 1; ben = 1; adn = 0; step();
      chk("R3 capture ignores enables ab", b_out, ~8'h96);
      chk("R3 capture ignores enables ba", a_out, ~8'h1E);

      // R2: strobe held high loads only once
      cap_ab = 1; ext_a = 8'h11; step();
      ext_a = 8'h22; step(); step();
      chk("R2 single load on rise", b_out, ~8'h11);
      cap_ab = 0; step();
      chk("R2 no load on fall", b_out, ~8'h11);

      // R8: stored output stays after live bus changes
      ext_a = 8'hE7; ext_b = 8'h5D; step();
      chk("R8 stored b after A change", b_out, ~8'h11);
      chk("R8 stored a after B change", a_out, ~8'h1E);
      sab = 0; sba = 0; ben = 0; step();
      chk("R5 live b inverted", b_out, ~8'hE7);
      chk("R5 live a inverted", a_out, ~8'h5D);

      // R6: bus hold with release of external A driver
      ext_a = 8'h5A; ben = 1; adn = 0; step();
      chk("R6 hold a_out", a_out, 8'h5A);
      chk("R6 hold b_out", b_out, 8'hA5);
      ext_a_en = 0; step(); step(); step();
      chk("R6 persist a_out", a_out, 8'h5A);
      chk("R6 persist b_out", b_out, 8'hA5);
      chk("R6 persist a bus", a_in, 8'h5A);
      ext_a_en = 1; step();

      // random mix
      for (int i = 0; i < 400; i++) begin
         {cap_ab, cap_ba, sab, sba, ben, adn} = 6'($urandom());
         ext_a = 8'($urandom()); ext_b = 8'($urandom());
         step();
         check_all("rand");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule